// File: doc/BRIEF.md
# Frame Buffer Pixel Unpacker

This block sits between a frame buffer word fetcher and the colour output stage of a display pipeline. It accepts 32-bit words over a ready/valid handshake and, each cycle that the output side requests a pixel, delivers one 24-bit RGB value with a valid strobe one clock later. Five pixel formats are supported. Packed 24-bit colour places four pixels in three words, so some pixels span a word boundary. Two 8-bit formats, greyscale and table-indexed colour, place four pixels in one word. RGB565 places two pixels in one word. The last format uses one word per pixel.

The unpacker keeps the low bytes of the last word it accepted, plus a position counter inside the current pixel group. It asks for a new word only when the next pixel needs one, so ready stays low while pixels are being drained from data it already holds. For table-indexed colour it places an 8-bit index on a lookup port and takes the 24-bit entry back in the same cycle. If a pixel is requested but its word has not arrived, the block outputs black, flags an underrun and stays at the same pixel position. The format is latched only while video is disabled, and disabling video returns the position counter to the start of a group.

Top module: `fb_pixel_unpack`

## Requirements
- R1: While reset is asserted, pix_valid, underrun and pix_rgb are all zero, even when pixels are requested.
- R2: word_ready is high only in a cycle where pix_req and video_en are both high and the next pixel needs a word the block does not yet hold. Depth codes are 0 = 8 bit, 1 = 16 bit, 2 = 24 bit and 3 = 32 bit. A word is taken when word_ready and word_valid are both high.
- R3: Depth 3 gives one pixel per word, and the pixel's RGB value is bits 23:0 of that word.
- R4: Depth 1 gives two pixels per word, bits 31:16 first. A 565 value r:g:b becomes {r,3'b0,g,2'b0,b,3'b0}.
- R5: Depth 0 with pseudo_sel low gives four pixels per word, bits 31:24 first. Each byte is copied into all three 8-bit channels.
- R6: Depth 0 with pseudo_sel high drives the pixel byte, in the same order as R5, on lut_addr and outputs lut_rgb. At any other depth, pseudo_sel has no effect.
- R7: Depth 2 gives four pixels per three words w0,w1,w2 in this order: w0[31:8], then {w0[7:0],w1[31:16]}, then {w1[15:0],w2[31:24]}, then w2[23:0].
- R8: If a requested pixel needs a word and word_valid is low, the next output has pix_valid high, underrun high and pix_rgb zero. The pixel position does not advance.
- R9: depth_sel and pseudo_sel are latched only in cycles where video_en is low. Such a cycle also resets the pixel position to the first pixel of a group.
- R10: pix_valid is high exactly one cycle after each cycle with pix_req and video_en both high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| video_en | input | 1 | Video enable; low allows format change and clears the position |
| depth_sel | input | 2 | Colour depth code (0=8, 1=16, 2=24, 3=32 bits) |
| pseudo_sel | input | 1 | Table-indexed colour when depth is 8 bit |
| word_data | input | 32 | Frame buffer word |
| word_valid | input | 1 | Word present |
| word_ready | output | 1 | Block takes word_data this cycle |
| pix_req | input | 1 | Output side requests a pixel this cycle |
| lut_addr | output | 8 | Colour table index |
| lut_rgb | input | 24 | Colour table entry for lut_addr, same cycle |
| pix_rgb | output | 24 | Pixel colour {red, green, blue} |
| pix_valid | output | 1 | pix_rgb holds the pixel requested in the previous cycle |
| underrun | output | 1 | Pixel was requested without its word; pix_rgb is black |

## Verification
word_ready and lut_addr are combinational, so they are due in the same cycle as the request. Each pixel, its valid strobe and its underrun flag are registered and are due one clock after the request. The bench drives inputs on the falling edge and checks word_ready 1 ns later, so it sees that cycle's inputs. It then compares the registered outputs on the next falling edge with the values it predicted for the previous cycle. Expected pixels are calculated from the pixel number and the word stream, using the packing rules above. The bench's own count of words taken decides when ready should be high.

// File: rtl/fbpu_pkg.sv
package fbpu_pkg;
  localparam int WORD_W = 32;
  localparam int CH_W   = 8;
  localparam int NCH    = 3;
  localparam int RGB_W  = CH_W * NCH;
  localparam int HALF_W = WORD_W / 2;
  localparam int SUB_W  = 2;

  typedef enum logic [1:0] {
    DEPTH_8  = 2'd0,
    DEPTH_16 = 2'd1,
    DEPTH_24 = 2'd2,
    DEPTH_32 = 2'd3
  } depth_e;

  typedef struct packed {
    depth_e depth;
    logic   pseudo;
  } mode_t;
endpackage

// File: rtl/fbpu_mode_reg.sv
module fbpu_mode_reg
  import fbpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       video_en,
  input  logic [1:0] depth_sel,
  input  logic       pseudo_sel,
  output mode_t      mode_q
);
  mode_t mode_d;

  always_comb begin
    mode_d = mode_q;
    if (!video_en) begin
      mode_d.depth  = depth_e'(depth_sel);
      mode_d.pseudo = pseudo_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '{depth: DEPTH_8, pseudo: 1'b0};
    else        mode_q <= mode_d;
  end

  // R9: the format cannot move while video runs
  p_mode_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    video_en |=> $stable(mode_q));
endmodule

// File: rtl/fbpu_seq.sv
module fbpu_seq
  import fbpu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  depth_e           depth,
  input  logic             video_en,
  input  logic             step,
  input  logic             take,
  input  logic [RGB_W-1:0] word_lo,
  output logic [SUB_W-1:0] sub_q,
  output logic [RGB_W-1:0] hold_q,
  output logic             need_word
);
  logic [SUB_W-1:0] sub_d;
  logic [SUB_W-1:0] sub_last;
  logic [RGB_W-1:0] hold_d;
  logic             hold_en;

  always_comb begin
    case (depth)
      DEPTH_8:  begin need_word = (sub_q == 2'd0); sub_last = 2'd3; end
      DEPTH_16: begin need_word = (sub_q == 2'd0); sub_last = 2'd1; end
      DEPTH_24: begin need_word = (sub_q != 2'd3); sub_last = 2'd3; end
      default:  begin need_word = 1'b1;            sub_last = 2'd0; end
    endcase
  end

  always_comb begin
    if (!video_en)  sub_d = '0;
    else if (step)  sub_d = (sub_q == sub_last) ? '0 : sub_q + 2'd1;
    else            sub_d = sub_q;
  end

  assign hold_en = take;
  assign hold_d  = word_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sub_q <= '0;
    else        sub_q <= sub_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end

  // R9: a disabled cycle leaves the group at its first pixel
  p_pos_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !video_en |=> (sub_q == '0));
  // R2: a word is only taken for a pixel that advances
  p_take_with_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> step);
  // R4: in 16-bit mode the position never leaves its pair
  p_half_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (depth == DEPTH_16 && video_en && $past(video_en) && $past(depth) == DEPTH_16)
      |-> (sub_q <= 2'd1));
endmodule

// File: rtl/fbpu_extract.sv
module fbpu_extract
  import fbpu_pkg::*;
(
  input  depth_e            depth,
  input  logic [SUB_W-1:0]  sub_q,
  input  logic [RGB_W-1:0]  hold_q,
  input  logic [WORD_W-1:0] word,
  output logic [CH_W-1:0]   byte_sel,
  output logic [HALF_W-1:0] half_sel,
  output logic [RGB_W-1:0]  direct_rgb
);
  always_comb begin
    case (sub_q)
      2'd0:    byte_sel = word[31:24];
      2'd1:    byte_sel = hold_q[23:16];
      2'd2:    byte_sel = hold_q[15:8];
      default: byte_sel = hold_q[7:0];
    endcase
  end

  assign half_sel = (sub_q == 2'd0) ? word[31:16] : hold_q[15:0];

  always_comb begin
    if (depth == DEPTH_32) begin
      direct_rgb = word[23:0];
    end else begin
      case (sub_q)
        2'd0:    direct_rgb = word[31:8];
        2'd1:    direct_rgb = {hold_q[7:0], word[31:16]};
        2'd2:    direct_rgb = {hold_q[15:0], word[31:24]};
        default: direct_rgb = hold_q[23:0];
      endcase
    end
  end
endmodule

// File: rtl/fbpu_colour.sv
module fbpu_colour
  import fbpu_pkg::*;
(
  input  mode_t             mode,
  input  logic [CH_W-1:0]   byte_sel,
  input  logic [HALF_W-1:0] half_sel,
  input  logic [RGB_W-1:0]  direct_rgb,
  input  logic [RGB_W-1:0]  lut_rgb,
  output logic [RGB_W-1:0]  rgb
);
  logic [RGB_W-1:0] grey;
  logic [RGB_W-1:0] wide565;

  for (genvar g = 0; g < NCH; g++) begin : g_grey
    assign grey[g*CH_W +: CH_W] = byte_sel;
  end

  assign wide565 = {half_sel[15:11], 3'b000, half_sel[10:5], 2'b00,
                    half_sel[4:0], 3'b000};

  always_comb begin
    case (mode.depth)
      DEPTH_8:  rgb = mode.pseudo ? lut_rgb : grey;
      DEPTH_16: rgb = wide565;
      default:  rgb = direct_rgb;
    endcase
  end
endmodule

// File: rtl/fb_pixel_unpack.sv
module fb_pixel_unpack
  import fbpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              video_en,
  input  logic [1:0]        depth_sel,
  input  logic              pseudo_sel,
  input  logic [WORD_W-1:0] word_data,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic              pix_req,
  output logic [CH_W-1:0]   lut_addr,
  input  logic [RGB_W-1:0]  lut_rgb,
  output logic [RGB_W-1:0]  pix_rgb,
  output logic              pix_valid,
  output logic              underrun
);
  logic [1:0]        rst_pipe;
  logic              rst_s_n;
  mode_t             mode_q;
  logic [SUB_W-1:0]  sub_q;
  logic [RGB_W-1:0]  hold_q;
  logic              need_word;
  logic              serve, take, step, starve;
  logic [CH_W-1:0]   byte_sel;
  logic [HALF_W-1:0] half_sel;
  logic [RGB_W-1:0]  direct_rgb, rgb;
  logic [RGB_W-1:0]  rgb_d;
  logic              valid_d, under_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1] & rst_n;

  fbpu_mode_reg u_mode (
    .clk(clk), .rst_n(rst_s_n), .video_en(video_en),
    .depth_sel(depth_sel), .pseudo_sel(pseudo_sel), .mode_q(mode_q));

  assign serve      = pix_req & video_en;
  assign word_ready = serve & need_word;
  assign take       = word_ready & word_valid;
  assign starve     = word_ready & ~word_valid;
  assign step       = serve & ~starve;

  fbpu_seq u_seq (
    .clk(clk), .rst_n(rst_s_n), .depth(mode_q.depth), .video_en(video_en),
    .step(step), .take(take), .word_lo(word_data[RGB_W-1:0]),
    .sub_q(sub_q), .hold_q(hold_q), .need_word(need_word));

  fbpu_extract u_extract (
    .depth(mode_q.depth), .sub_q(sub_q), .hold_q(hold_q), .word(word_data),
    .byte_sel(byte_sel), .half_sel(half_sel), .direct_rgb(direct_rgb));

  assign lut_addr = byte_sel;

  fbpu_colour u_colour (
    .mode(mode_q), .byte_sel(byte_sel), .half_sel(half_sel),
    .direct_rgb(direct_rgb), .lut_rgb(lut_rgb), .rgb(rgb));

  always_comb begin
    valid_d = serve;
    under_d = starve;
    if (starve)     rgb_d = '0;
    else if (serve) rgb_d = rgb;
    else            rgb_d = pix_rgb;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      pix_valid <= 1'b0;
      underrun  <= 1'b0;
      pix_rgb   <= '0;
    end else begin
      pix_valid <= valid_d;
      underrun  <= under_d;
      pix_rgb   <= rgb_d;
    end
  end

  // R2: no word is asked for unless a pixel is wanted
  p_ready_gated_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    word_ready |-> (pix_req && video_en));
  // R8: an underrun pixel is a valid black pixel
  p_underrun_black_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    underrun |-> (pix_valid && pix_rgb == '0));
  // R8: a starved request is answered with the flag
  p_starve_flag_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (word_ready && !word_valid) |=> underrun);
  // R10: one output per request, one cycle later
  p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (pix_req && video_en) |=> pix_valid);
  p_valid_idle_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(pix_req && video_en) |=> !pix_valid);
endmodule

// File: tb/fb_pixel_unpack_bench.sv
module fb_pixel_unpack_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        video_en, pseudo_sel, word_valid, pix_req;
  logic [1:0]  depth_sel;
  logic [31:0] word_data;
  logic        word_ready;
  logic [7:0]  lut_addr;
  logic [23:0] lut_rgb;
  logic [23:0] pix_rgb;
  logic        pix_valid, underrun;

  int n_checks = 0;
  int n_fail   = 0;

  logic [31:0] mem [64];
  int          b_pn, b_cons, b_base;
  logic [1:0]  b_depth;
  logic        b_pseudo;
  logic [1:0]  cur_dsel;
  logic        cur_psel;
  logic        exp_valid, exp_und;
  logic [23:0] exp_rgb;
  string       exp_tag;
  string       tag_force;

  always #10 clk = ~clk;

  function automatic logic [31:0] lut_entry(input logic [7:0] a);
    return {8'hC3, ~a, a ^ 8'h5A, a + 8'd17};
  endfunction

  logic [31:0] lut_full;
  assign lut_full = lut_entry(lut_addr);
  assign lut_rgb  = lut_full[23:0];

  fb_pixel_unpack u_fb_pixel_unpack (
    .clk(clk), .rst_n(rst_n), .video_en(video_en), .depth_sel(depth_sel),
    .pseudo_sel(pseudo_sel), .word_data(word_data), .word_valid(word_valid),
    .word_ready(word_ready), .pix_req(pix_req), .lut_addr(lut_addr),
    .lut_rgb(lut_rgb), .pix_rgb(pix_rgb), .pix_valid(pix_valid),
    .underrun(underrun));

  function automatic int last_word(input logic [1:0] d, input int pn);
    case (d)
      2'd0: return pn / 4;
      2'd1: return pn / 2;
      2'd2: return (pn / 4) * 3 + ((pn % 4 == 3) ? 2 : pn % 4);
      default: return pn;
    endcase
  endfunction

  function automatic logic [31:0] wd(input int r);
    return mem[(b_base + r) & 63];
  endfunction

  function automatic logic [23:0] pix_expect(input logic [1:0] d,
                                             input logic ps, input int pn);
    logic [31:0] w0, w1, w2;
    logic [15:0] h;
    logic [7:0]  b;
    int g;
    case (d)
      2'd3: begin w0 = wd(pn); return w0[23:0]; end
      2'd1: begin
        w0 = wd(pn / 2);
        h = (pn % 2 == 0) ? w0[31:16] : w0[15:0];
        return {h[15:11], 3'b0, h[10:5], 2'b0, h[4:0], 3'b0};
      end
      2'd0: begin
        w0 = wd(pn / 4);
        b = 8'(w0 >> (8 * (3 - pn % 4)));
        if (ps) begin w1 = lut_entry(b); return w1[23:0]; end
        return {b, b, b};
      end
      default: begin
        g = (pn / 4) * 3;
        w0 = wd(g); w1 = wd(g + 1); w2 = wd(g + 2);
        case (pn % 4)
          0: return w0[31:8];
          1: return {w0[7:0], w1[31:16]};
          2: return {w1[15:0], w2[31:24]};
          default: return w2[23:0];
        endcase
      end
    endcase
  endfunction

  function automatic string mode_tag(input logic [1:0] d, input logic ps);
    case (d)
      2'd0: return ps ? "R6" : "R5";
      2'd1: return ps ? "R6" : "R4";
      2'd2: return ps ? "R6" : "R7";
      default: return ps ? "R6" : "R3";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [25:0] act, input logic [25:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cycle(input bit en, input bit rq, input bit vl);
    bit need, exp_ready;
    @(negedge clk);
    if (exp_valid)
      check(pix_valid === 1'b1 && underrun === exp_und && pix_rgb === exp_rgb,
            exp_tag, {pix_valid, underrun, pix_rgb}, {1'b1, exp_und, exp_rgb});
    else
      check(pix_valid === 1'b0, "R10", {25'd0, pix_valid}, 26'd0);
    video_en   = en;
    pix_req    = rq;
    word_valid = vl;
    depth_sel  = cur_dsel;
    pseudo_sel = cur_psel;
    word_data  = mem[b_cons & 63];
    #1;
    if (!en) begin
      b_depth = cur_dsel; b_pseudo = cur_psel;
      b_pn = 0; b_base = b_cons;
      exp_valid = 1'b0;
      check(word_ready === 1'b0, "R2", {25'd0, word_ready}, 26'd0);
    end else begin
      need = (last_word(b_depth, b_pn) == b_cons - b_base);
      exp_ready = rq && need;
      check(word_ready === exp_ready, "R2", {25'd0, word_ready}, {25'd0, exp_ready});
      exp_valid = rq;
      if (rq) begin
        if (need && !vl) begin
          exp_und = 1'b1; exp_rgb = '0; exp_tag = "R8";
        end else begin
          exp_und = 1'b0;
          exp_rgb = pix_expect(b_depth, b_pseudo, b_pn);
          exp_tag = (tag_force != "") ? tag_force : mode_tag(b_depth, b_pseudo);
          if (need) b_cons++;
          b_pn++;
        end
      end
    end
  endtask

  task automatic segment(input logic [1:0] d, input logic ps, input int n,
                         input int req_pct, input int val_pct);
    cur_dsel = d; cur_psel = ps;
    repeat (2) cycle(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < n; i++)
      cycle(1'b1, ($urandom % 100) < req_pct, ($urandom % 100) < val_pct);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h1F2E3D4C);
    for (int i = 0; i < 64; i++) mem[i] = $urandom;
    b_pn = 0; b_cons = 0; b_base = 0; b_depth = 2'd0; b_pseudo = 1'b0;
    cur_dsel = 2'd0; cur_psel = 1'b0; tag_force = "";
    exp_valid = 1'b0; exp_und = 1'b0; exp_rgb = '0; exp_tag = "R10";
    rst_n = 1'b0; video_en = 1'b1; pix_req = 1'b1; word_valid = 1'b1;
    depth_sel = 2'd3; pseudo_sel = 1'b0; word_data = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs stay cleared under reset despite active requests
    check(pix_valid === 1'b0 && underrun === 1'b0 && pix_rgb === 24'd0, "R1",
          {pix_valid, underrun, pix_rgb}, 26'd0);
    video_en = 1'b0; pix_req = 1'b0; word_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(pix_valid === 1'b0 && underrun === 1'b0, "R1",
          {pix_valid, underrun, 24'd0}, 26'd0);

    // every format under random request and arrival patterns
    segment(2'd0, 1'b0, 400, 80, 75);
    segment(2'd0, 1'b1, 400, 80, 75);
    segment(2'd1, 1'b0, 400, 80, 75);
    segment(2'd1, 1'b1, 300, 70, 90);
    segment(2'd2, 1'b0, 400, 80, 75);
    segment(2'd2, 1'b0, 200, 100, 100);
    segment(2'd3, 1'b0, 300, 80, 75);
    segment(2'd3, 1'b1, 200, 90, 60);

    // R8: a long starvation with requests held high
    segment(2'd2, 1'b0, 5, 100, 100);
    for (int i = 0; i < 6; i++) cycle(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 12; i++) cycle(1'b1, 1'b1, 1'b1);

    // R9: a format change is ignored while enabled, and disabling mid group
    tag_force = "R9";
    segment(2'd2, 1'b0, 6, 100, 100);
    cur_dsel = 2'd3; cur_psel = 1'b1;
    for (int i = 0; i < 40; i++) cycle(1'b1, ($urandom % 100) < 85, 1'b1);
    cur_dsel = 2'd2; cur_psel = 1'b0;
    for (int i = 0; i < 5; i++) cycle(1'b1, 1'b1, 1'b1);
    cycle(1'b0, 1'b1, 1'b1);
    cur_dsel = 2'd1;
    for (int i = 0; i < 30; i++) cycle(1'b1, 1'b1, ($urandom % 100) < 80);
    cycle(1'b0, 1'b0, 1'b0);
    cur_dsel = 2'd0; cur_psel = 1'b1;
    for (int i = 0; i < 30; i++) cycle(1'b1, 1'b1, 1'b1);
    tag_force = "";
    cycle(1'b0, 1'b0, 1'b0);
    cycle(1'b0, 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule